// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit datapath. It takes one operand, a shift kind, a shift amount and the current carry flag. It returns the shifted operand and a shifter carry-out that follows the architectural rules for each kind. The supported kinds are:

- logical left
- logical right
- arithmetic right
- rotate right
- rotate right by one through the carry
- rotate right that leaves the carry untouched

The amount normally comes from an 8-bit register value. Amounts of the operand width or more saturate in a defined way. Instead of that register value, the amount can come from a 4-bit rotate field of an immediate operand. That field selects a rotate right by twice its value.

The shifting logic is combinational. Its outputs are captured in one register stage, so a result appears one clock after its inputs. A synchronous active-low reset clears that stage. The block decodes no instruction fields and reads no register file. A caller that uses a zero immediate shift count to encode a special case must present that case as the matching register amount.

Top module: `barrel_carry_shifter`

## Requirements
- R1: Outputs are registered. `result_o` and `carry_o` reflect the inputs present at the previous rising clock edge. While `rst_n` is low at a rising edge, both are cleared to 0.
- R2: With `imm_sel_i`=0, an amount of 0 and kind 0, 1, 2 or 3, the operand passes through unchanged and `carry_o` equals `carry_i`.
- R3: Kind 0 is logical left. For amounts 1 to 31 the result is the operand shifted left with zero fill, and the carry is operand bit 32-n. An amount of 32 gives result 0 with carry equal to operand bit 0. Amounts 33 to 255 give result 0 and carry 0.
- R4: Kind 1 is logical right. For amounts 1 to 31 the result has zero fill and the carry is operand bit n-1. An amount of 32 gives result 0 with carry equal to operand bit 31. Amounts 33 to 255 give result 0 and carry 0.
- R5: Kind 2 is arithmetic right. For amounts 1 to 31 the result is filled with the sign bit and the carry is operand bit n-1. Amounts of 32 or more give every result bit equal to operand bit 31, and the carry is also operand bit 31.
- R6: Kind 3 is rotate right by the amount modulo 32, with carry equal to operand bit (n mod 32)-1. A nonzero multiple of 32 leaves the operand unchanged and sets the carry to operand bit 31.
- R7: Kind 4 rotates right by exactly one through the carry, whatever the amount. `carry_i` enters bit 31 and operand bit 0 becomes `carry_o`.
- R8: Kind 5 rotates right by the amount modulo 32 and always returns `carry_i` as `carry_o`.
- R9: With `imm_sel_i`=1, `kind_i` and `amt_i` are ignored, and the block rotates right by twice `rot_i`. The carry is operand bit 2*rot-1. When `rot_i`=0, the operand and `carry_i` pass through unchanged.
- R10: With `imm_sel_i`=0, kinds 6 and 7 pass the operand and `carry_i` through unchanged for any amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 3 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5 ROR keeping carry, 6/7 pass) |
| amt_i | input | 8 | Register-derived shift amount, 0 to 255 |
| imm_sel_i | input | 1 | 1 selects the immediate rotate field as the amount source |
| rot_i | input | 4 | Immediate rotate field; rotate amount is twice this value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
The assertions assume that every input carries a known value on each rising edge after reset is released. They also assume the inputs stay stable from one rising edge to the next, so the value captured by `$past` is the one the register stage used. The bench meets both assumptions: it changes inputs only on the falling edge and never leaves an input unset once reset is released. Its amounts cover zero, one, 31, the width, one past the width and the largest 8-bit value, together with random amounts. Every kind code from 0 to 7 and both amount sources are driven.

// File: rtl/bcs_pkg.sv
// Package: shared kind codes for the barrel carry shifter.
// Assumes: kind field is 3 bits wide; codes 6 and 7 are pass-through.
package bcs_pkg;
    localparam int KIND_W = 3;
    localparam logic [KIND_W-1:0] K_LSL      = 3'd0;
    localparam logic [KIND_W-1:0] K_LSR      = 3'd1;
    localparam logic [KIND_W-1:0] K_ASR      = 3'd2;
    localparam logic [KIND_W-1:0] K_ROR      = 3'd3;
    localparam logic [KIND_W-1:0] K_RRX      = 3'd4;
    localparam logic [KIND_W-1:0] K_ROR_KEEP = 3'd5;
endpackage

// File: rtl/bcs_amount_sel.sv
// Module: picks the shift amount and kind from either the register
// amount or the immediate rotate field (rotate right by twice the field).
// Assumes: RW+1 <= AW so the doubled field fits the amount width.
module bcs_amount_sel
    import bcs_pkg::*;
#(
    parameter int AW = 8,
    parameter int RW = 4
) (
    input  logic              imm_sel_i,
    input  logic [RW-1:0]     rot_i,
    input  logic [AW-1:0]     amt_i,
    input  logic [KIND_W-1:0] kind_i,
    output logic [AW-1:0]     amt_o,
    output logic [KIND_W-1:0] kind_o
);
    localparam int PAD = AW - RW - 1;

    // Route the immediate rotate as a ROR, otherwise pass the register form.
    always_comb begin
        if (imm_sel_i) begin
            amt_o  = {{PAD{1'b0}}, rot_i, 1'b0};
            kind_o = K_ROR;
        end else begin
            amt_o  = amt_i;
            kind_o = kind_i;
        end
    end
endmodule

// File: rtl/bcs_stage_chain.sv
// Module: logarithmic shifter of SW stages, each moving by a power of two.
// LEFT=1 shifts left with zero fill; otherwise right with fill_i,
// or a rotate when WRAP=1. Assumes W > 2**(SW-1).
module bcs_stage_chain #(
    parameter int W    = 32,
    parameter int SW   = 5,
    parameter bit LEFT = 1'b0,
    parameter bit WRAP = 1'b0
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          fill_i,
    output logic [W-1:0]  data_o
);
    logic [SW:0][W-1:0] st;

    assign st[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] moved;
        if (LEFT) begin : g_left
            // Move left by S, zeros enter at the bottom.
            assign moved = {st[k][W-S-1:0], {S{1'b0}}};
        end else if (WRAP) begin : g_wrap
            // Rotate right by S, low bits wrap to the top.
            assign moved = {st[k][S-1:0], st[k][W-1:S]};
        end else begin : g_fill
            // Move right by S, fill bit enters at the top.
            assign moved = {{S{fill_i}}, st[k][W-1:S]};
        end
        // Apply this stage only when its amount bit is set.
        assign st[k+1] = amt_i[k] ? moved : st[k];
    end

    assign data_o = st[SW];
endmodule

// File: rtl/bcs_core.sv
// Module: combinational shift core; selects the result and carry-out
// per kind, including saturation for amounts at or above the width.
// Assumes: W is a power of two and AW > log2(W).
module bcs_core
    import bcs_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]      opnd_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [AW-1:0]     amt_i,
    input  logic              carry_i,
    output logic [W-1:0]      res_o,
    output logic              carry_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] n_low;
    logic [SW-1:0] idx_r;
    logic [SW-1:0] idx_l;
    logic          over;
    logic          at_w;
    logic          is_zero;
    logic          msb;
    logic [W-1:0]  lsl_v, lsr_v, asr_v, ror_v;

    assign n_low   = amt_i[SW-1:0];
    assign over    = |amt_i[AW-1:SW];
    assign at_w    = (amt_i == AW'(W));
    assign is_zero = (amt_i == '0);
    assign msb     = opnd_i[W-1];
    assign idx_r   = n_low - SW'(1);
    assign idx_l   = SW'(0) - n_low;

    bcs_stage_chain #(.W(W), .SW(SW), .LEFT(1'b1), .WRAP(1'b0)) u_lsl (
        .data_i(opnd_i), .amt_i(n_low), .fill_i(1'b0), .data_o(lsl_v));
    bcs_stage_chain #(.W(W), .SW(SW), .LEFT(1'b0), .WRAP(1'b0)) u_lsr (
        .data_i(opnd_i), .amt_i(n_low), .fill_i(1'b0), .data_o(lsr_v));
    bcs_stage_chain #(.W(W), .SW(SW), .LEFT(1'b0), .WRAP(1'b0)) u_asr (
        .data_i(opnd_i), .amt_i(n_low), .fill_i(msb), .data_o(asr_v));
    bcs_stage_chain #(.W(W), .SW(SW), .LEFT(1'b0), .WRAP(1'b1)) u_ror (
        .data_i(opnd_i), .amt_i(n_low), .fill_i(1'b0), .data_o(ror_v));

    // Choose result and carry-out by kind and amount range.
    always_comb begin
        res_o   = opnd_i;
        carry_o = carry_i;
        unique case (kind_i)
            K_LSL: begin
                if (is_zero) begin
                    res_o = opnd_i;
                end else if (!over) begin
                    res_o   = lsl_v;
                    carry_o = opnd_i[idx_l];
                end else begin
                    res_o   = '0;
                    carry_o = at_w ? opnd_i[0] : 1'b0;
                end
            end
            K_LSR: begin
                if (is_zero) begin
                    res_o = opnd_i;
                end else if (!over) begin
                    res_o   = lsr_v;
                    carry_o = opnd_i[idx_r];
                end else begin
                    res_o   = '0;
                    carry_o = at_w ? msb : 1'b0;
                end
            end
            K_ASR: begin
                if (is_zero) begin
                    res_o = opnd_i;
                end else if (!over) begin
                    res_o   = asr_v;
                    carry_o = opnd_i[idx_r];
                end else begin
                    res_o   = {W{msb}};
                    carry_o = msb;
                end
            end
            K_ROR: begin
                if (is_zero) begin
                    res_o = opnd_i;
                end else if (n_low == '0) begin
                    res_o   = opnd_i;
                    carry_o = msb;
                end else begin
                    res_o   = ror_v;
                    carry_o = opnd_i[idx_r];
                end
            end
            K_RRX: begin
                res_o   = {carry_i, opnd_i[W-1:1]};
                carry_o = opnd_i[0];
            end
            K_ROR_KEEP: begin
                res_o = ror_v;
            end
            default: begin
                res_o   = opnd_i;
                carry_o = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/barrel_carry_shifter.sv
// Module: top of the barrel carry shifter. Selects the amount source,
// runs the combinational core and registers result and carry.
// Assumes: inputs are known at every rising edge after reset release.
module barrel_carry_shifter
    import bcs_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter int RW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      opnd_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [AW-1:0]     amt_i,
    input  logic              imm_sel_i,
    input  logic [RW-1:0]     rot_i,
    input  logic              carry_i,
    output logic [W-1:0]      result_o,
    output logic              carry_o
);
    logic [AW-1:0]     amt_s;
    logic [KIND_W-1:0] kind_s;
    logic [W-1:0]      res_c;
    logic              carry_c;

    bcs_amount_sel #(.AW(AW), .RW(RW)) u_sel (
        .imm_sel_i(imm_sel_i), .rot_i(rot_i), .amt_i(amt_i), .kind_i(kind_i),
        .amt_o(amt_s), .kind_o(kind_s));

    bcs_core #(.W(W), .AW(AW)) u_core (
        .opnd_i(opnd_i), .kind_i(kind_s), .amt_i(amt_s), .carry_i(carry_i),
        .res_o(res_c), .carry_o(carry_c));

    // Output register stage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else begin
            result_o <= res_c;
            carry_o  <= carry_c;
        end
    end

    // R2
    zero_amt_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && amt_i == '0 && kind_i <= K_ROR)
        |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));

    // R3
    lsl_wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && kind_i == K_LSL && amt_i > AW'(W))
        |=> (result_o == '0 && !carry_o));

    // R5
    asr_wide_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && kind_i == K_ASR && amt_i >= AW'(W))
        |=> (result_o == {W{$past(opnd_i[W-1])}} && carry_o == $past(opnd_i[W-1])));

    // R7
    rrx_through_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && kind_i == K_RRX)
        |=> (result_o[W-1] == $past(carry_i) && carry_o == $past(opnd_i[0])));

    // R8
    ror_keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && kind_i == K_ROR_KEEP)
        |=> (carry_o == $past(carry_i)));

    // R9
    imm_rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_sel_i && rot_i == '0)
        |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));
endmodule

// File: tb/barrel_carry_shifter_tb_top.sv
`timescale 1ns/1ps
module barrel_carry_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] opnd;
    logic [2:0]  kind;
    logic [7:0]  amt;
    logic        imm_sel;
    logic [3:0]  rot;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    barrel_carry_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd), .kind_i(kind), .amt_i(amt),
        .imm_sel_i(imm_sel), .rot_i(rot), .carry_i(cin),
        .result_o(result), .carry_o(cout));

    // Vector: {imm, rot[4], kind[3], amt[8], opnd[32], cin, exp_res[32], exp_c}
    localparam int NV = 18;
    localparam logic [81:0] VECS [NV] = '{
        {1'b0, 4'd0, 3'd0, 8'd1,   32'h80000001, 1'b0, 32'h00000002, 1'b1}, // R3
        {1'b0, 4'd0, 3'd0, 8'd32,  32'h00000001, 1'b0, 32'h00000000, 1'b1}, // R3
        {1'b0, 4'd0, 3'd0, 8'd33,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0}, // R3
        {1'b0, 4'd0, 3'd1, 8'd1,   32'h00000003, 1'b0, 32'h00000001, 1'b1}, // R4
        {1'b0, 4'd0, 3'd1, 8'd32,  32'h80000000, 1'b0, 32'h00000000, 1'b1}, // R4
        {1'b0, 4'd0, 3'd1, 8'd255, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0}, // R4
        {1'b0, 4'd0, 3'd2, 8'd31,  32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b0}, // R5
        {1'b0, 4'd0, 3'd2, 8'd255, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b1}, // R5
        {1'b0, 4'd0, 3'd3, 8'd4,   32'h12345678, 1'b0, 32'h81234567, 1'b1}, // R6
        {1'b0, 4'd0, 3'd3, 8'd32,  32'h80000000, 1'b0, 32'h80000000, 1'b1}, // R6
        {1'b0, 4'd0, 3'd3, 8'd36,  32'h12345678, 1'b0, 32'h81234567, 1'b1}, // R6
        {1'b0, 4'd0, 3'd4, 8'd77,  32'h00000001, 1'b1, 32'h80000000, 1'b1}, // R7
        {1'b0, 4'd0, 3'd0, 8'd0,   32'hDEADBEEF, 1'b1, 32'hDEADBEEF, 1'b1}, // R2
        {1'b0, 4'd0, 3'd5, 8'd8,   32'h12345678, 1'b0, 32'h78123456, 1'b0}, // R8
        {1'b0, 4'd0, 3'd6, 8'd5,   32'hCAFEF00D, 1'b1, 32'hCAFEF00D, 1'b1}, // R10
        {1'b1, 4'd2, 3'd6, 8'd200, 32'h12345678, 1'b0, 32'h81234567, 1'b1}, // R9
        {1'b1, 4'd0, 3'd0, 8'd9,   32'hA5A5A5A5, 1'b1, 32'hA5A5A5A5, 1'b1}, // R9
        {1'b1, 4'd15,3'd1, 8'd3,   32'h00000001, 1'b1, 32'h00000004, 1'b0}  // R9
    };

    // Behavioural model written from the requirements.
    function automatic logic [32:0] model(input logic im, input logic [3:0] rf,
                                          input logic [2:0] k, input logic [7:0] a,
                                          input logic [31:0] v, input logic c);
        int n;
        int m;
        logic [31:0] r;
        logic co;
        r  = v;
        co = c;
        if (im) begin
            n = 2 * int'(rf);
            if (n != 0) begin
                r  = (v >> n) | (v << (32 - n));
                co = v[n-1];
            end
        end else begin
            n = int'(a);
            m = n % 32;
            case (k)
                3'd0: if (n != 0) begin
                    if (n < 32) begin r = v << n; co = v[32-n]; end
                    else if (n == 32) begin r = '0; co = v[0]; end
                    else begin r = '0; co = 1'b0; end
                end
                3'd1: if (n != 0) begin
                    if (n < 32) begin r = v >> n; co = v[n-1]; end
                    else if (n == 32) begin r = '0; co = v[31]; end
                    else begin r = '0; co = 1'b0; end
                end
                3'd2: if (n != 0) begin
                    if (n < 32) begin r = 32'($signed(v) >>> n); co = v[n-1]; end
                    else begin r = {32{v[31]}}; co = v[31]; end
                end
                3'd3: if (n != 0) begin
                    if (m == 0) co = v[31];
                    else begin r = (v >> m) | (v << (32 - m)); co = v[m-1]; end
                end
                3'd4: begin r = {c, v[31:1]}; co = v[0]; end
                3'd5: if (m != 0) r = (v >> m) | (v << (32 - m));
                default: ;
            endcase
        end
        return {r, co};
    endfunction

    function automatic string req_of(input logic im, input logic [2:0] k, input logic [7:0] a);
        if (im) return "R9";
        if (a == 8'd0 && k <= 3'd3) return "R2";
        case (k)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic ec);
        n_checks++;
        if (result !== er || cout !== ec) begin
            n_fails++;
            $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b", req, result, cout, er, ec);
        end
    endtask

    // Drive on a falling edge; the result is registered at the next rising edge.
    task automatic apply(input logic im, input logic [3:0] rf, input logic [2:0] k,
                         input logic [7:0] a, input logic [31:0] v, input logic c);
        @(negedge clk);
        imm_sel = im; rot = rf; kind = k; amt = a; opnd = v; cin = c;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [32:0] exp_v;
        logic [7:0]  amt_set [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
        rst_n = 1'b0; imm_sel = 1'b0; rot = '0; kind = '0; amt = '0; opnd = '0; cin = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", 32'h0, 1'b0);
        // R1: inputs during reset must not reach the outputs.
        opnd = 32'hFFFFFFFF; cin = 1'b1; kind = 3'd6;
        @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [81:0] vv;
            vv = VECS[i];
            apply(vv[81], vv[80:77], vv[76:74], vv[73:66], vv[65:34], vv[33]);
            check(req_of(vv[81], vv[76:74], vv[73:66]), vv[32:1], vv[0]);
        end

        // Random operands over all kinds, boundary and random amounts.
        for (int i = 0; i < 600; i++) begin
            logic        im;
            logic [3:0]  rf;
            logic [2:0]  k;
            logic [7:0]  a;
            logic [31:0] v;
            logic        c;
            im = ($urandom % 6) == 0;
            rf = 4'($urandom);
            k  = 3'($urandom);
            a  = (i % 2 == 0) ? amt_set[i/2 % 6] : 8'($urandom);
            v  = $urandom;
            c  = 1'($urandom);
            apply(im, rf, k, a, v, c);
            exp_v = model(im, rf, k, a, v, c);
            check(req_of(im, k, a), exp_v[32:1], exp_v[0]);
        end

        // R1: back-to-back inputs each appear exactly one cycle later.
        @(negedge clk);
        imm_sel = 1'b0; kind = 3'd0; amt = 8'd4; opnd = 32'h0000000F; cin = 1'b0;
        @(negedge clk);
        check("R1", 32'h000000F0, 1'b0);
        kind = 3'd1; amt = 8'd4; opnd = 32'h000000F8;
        @(negedge clk);
        check("R1", 32'h0000000F, 1'b1);

        // R1: reset in mid-run clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule